// File: doc/BRIEF.md
# Banked Memory Parity Guard

This block sits between a processor bus and a set of byte-wide memory banks and adds a ninth bit to every stored byte. Each bank is chosen by its own row strobe. On a write, the block computes an odd parity bit over the data byte. It stores that bit in its own parity array, indexed by bank and address. The data byte itself goes to the external memory.

On a read, the byte returned by the selected bank is checked against the stored bit. The nine bits together must hold an odd number of ones. If the check fails, the block records which bank strobe was active and lights that bank's indicator. It also raises a halt request to the processor. The block only detects errors: it does not correct them, and it does not model memory timing or refresh.

An access is one clock cycle with `acc_valid` high. The error state is held until `err_clear` or reset. The first failing bank stays recorded while the halt is held.

Top module: `bank_parity_guard`

## Requirements
- R1: On a qualified write, the block stores the bit that makes the count of ones in {data, bit} odd, for that bank and address. Reading back the same byte then passes the check.
- R2: A qualified read whose byte, together with the stored bit, has an odd count of ones leaves `halt_req` low and `err_bank` all zero.
- R3: A qualified read whose byte, together with the stored bit, has an even count of ones sets `halt_req` high in the cycle after the access edge. This covers any single-bit change from the written byte.
- R4: Bit i of `bank_sel` selects bank i. On an error, `err_bank` becomes the one-hot vector with bit i set for the bank that was read.
- R5: While `halt_req` is high and `err_clear` is low, `halt_req` stays high and `err_bank` does not change, even if another read in any bank fails.
- R6: Writes and cycles with `acc_valid` low never set `halt_req`, whatever the value on `rd_data`.
- R7: `err_clear` drops `halt_req` and `err_bank` after the next edge. If a failing read occurs in the same cycle as the clear, that new error is latched instead.
- R8: After reset, `halt_req` is low and `err_bank` is zero. Every parity entry holds the bit for an all-zero byte, so reading 8'h00 from an unwritten location passes and reading 8'h01 fails.
- R9: An access is qualified only when exactly one bit of `bank_sel` is set. An unqualified access writes nothing and checks nothing.
- R10: The same address in different banks holds separate parity bits.
- R11: A read byte that differs from the written byte in two bit positions passes the check, because only odd parity is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access completes this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| bank_sel | input | 4 | Row strobe per bank, one-hot |
| acc_addr | input | 8 | Byte address within the bank |
| wr_data | input | 8 | Byte being written |
| rd_data | input | 8 | Byte returned by the bank on a read |
| err_clear | input | 1 | Clears the latched error |
| halt_req | output | 1 | Halt request to the processor |
| err_bank | output | 4 | One-hot indicator of the failing bank |

## Verification
The assertions check, on every cycle, several properties of the error state. The indicator must be one-hot or zero, and it must be nonzero exactly when the halt is raised. The halt must stay up and the recorded bank must stay unchanged until a clear. Neither a write nor an idle cycle may raise the halt. The assertions cannot tell whether a given read byte should fail, because that depends on the earlier write to that bank and address. The bench scenarios show that instead: which bytes are caught, and which double-bit changes are missed. They also show that banks are kept apart, that reset leaves zero-byte parity in every entry, and that an access with a bad strobe pattern is dropped.

// File: rtl/pg_pkg.sv
// Shared definitions for the parity guard.
// Assumes: accesses are classified once per cycle by the top module.
package pg_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/pg_parity_gen.sv
// Odd parity generator: returns the bit that makes the total count of ones
// in {data, bit} odd. Purely combinational.
module pg_parity_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         odd_bit
);
    // Odd parity is the inverse of the XOR reduction.
    always_comb odd_bit = ~(^data);
endmodule

// File: rtl/pg_parity_store.sv
// Behavioural parity array: one bit per bank and address.
// Assumes: write index is valid when wr_en is high; read is asynchronous.
// Reset fills every entry with the parity of an all-zero byte (1).
module pg_parity_store #(
    parameter int NB     = 4,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NB)-1:0]  bank,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_bit,
    output logic                   rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] par_mem [NB];

    // Reset to zero-byte parity, otherwise capture the generated bit on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) par_mem[b] <= '1;
        end else if (wr_en) begin
            par_mem[bank][addr] <= wr_bit;
        end
    end

    // Stored bit for the addressed location.
    always_comb rd_bit = par_mem[bank][addr];
endmodule

// File: rtl/pg_error_latch.sv
// Sticky error latch: keeps the first failing bank until a clear or reset.
// Assumes: err_onehot is one-hot whenever err_event is high.
// A new error in the same cycle as a clear is kept.
module pg_error_latch #(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_event,
    input  logic [NB-1:0] err_onehot,
    input  logic          clear,
    output logic [NB-1:0] err_bank,
    output logic          halt
);
    // Capture the first error; a clear frees the latch for a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_bank <= '0;
            halt     <= 1'b0;
        end else if (err_event && (!halt || clear)) begin
            err_bank <= err_onehot;
            halt     <= 1'b1;
        end else if (clear) begin
            err_bank <= '0;
            halt     <= 1'b0;
        end
    end
endmodule

// File: rtl/bank_parity_guard.sv
// Top module of the parity guard. It stores an odd parity bit per written
// byte and checks that bit on completed reads. On a failure it latches the
// active bank strobe and requests a halt.
// Assumes: one access per cycle; rd_data is valid in the read cycle.
module bank_parity_guard #(
    parameter int NB     = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [NB-1:0]     bank_sel,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              err_clear,
    output logic              halt_req,
    output logic [NB-1:0]     err_bank
);
    import pg_pkg::*;

    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1;

    acc_kind_t         kind;
    logic [BANK_W-1:0] bank_idx;
    logic              wr_par;
    logic              rd_par_calc;
    logic              rd_par_stored;
    logic              mismatch;

    // Classify the cycle; only a single active strobe qualifies an access.
    always_comb begin
        if (!acc_valid || !$onehot(bank_sel)) kind = ACC_IDLE;
        else if (acc_write)                   kind = ACC_WRITE;
        else                                  kind = ACC_READ;
    end

    // Encode the one-hot strobe into a bank index.
    always_comb begin
        bank_idx = '0;
        for (int i = 0; i < NB; i++)
            if (bank_sel[i]) bank_idx = BANK_W'(i);
    end

    pg_parity_gen #(.W(DATA_W)) u_gen_wr (
        .data    (wr_data),
        .odd_bit (wr_par)
    );

    pg_parity_gen #(.W(DATA_W)) u_gen_rd (
        .data    (rd_data),
        .odd_bit (rd_par_calc)
    );

    pg_parity_store #(.NB(NB), .ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (kind == ACC_WRITE),
        .bank   (bank_idx),
        .addr   (acc_addr),
        .wr_bit (wr_par),
        .rd_bit (rd_par_stored)
    );

    // A read fails when the returned byte needs a different odd bit than stored.
    always_comb mismatch = (kind == ACC_READ) && (rd_par_calc != rd_par_stored);

    pg_error_latch #(.NB(NB)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_event  (mismatch),
        .err_onehot (bank_sel),
        .clear      (err_clear),
        .err_bank   (err_bank),
        .halt       (halt_req)
    );
endmodule

// File: rtl/bank_parity_guard_chk.sv
// Checker for the parity guard: properties over ports and latched state.
module bank_parity_guard_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_write,
    input logic          err_clear,
    input logic          halt_req,
    input logic [NB-1:0] err_bank
);
    // R4: indicator is one-hot or empty.
    p_onehot_ind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_bank));

    // R3: indicator is lit exactly while the halt is requested.
    p_halt_ind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req == (err_bank != '0));

    // R5: halt holds until cleared.
    p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !err_clear |=> halt_req);

    // R5: first bank is kept while halted.
    p_bank_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !err_clear |=> $stable(err_bank));

    // R6: only a completed read can raise the halt.
    p_no_set_wr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req && !(acc_valid && !acc_write) |=> !halt_req);

    // R7: clear with no read access leaves the latch empty.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear && !(acc_valid && !acc_write) |=> !halt_req);
endmodule

bind bank_parity_guard bank_parity_guard_chk #(.NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .err_clear (err_clear),
    .halt_req  (halt_req),
    .err_bank  (err_bank)
);

// File: tb/tb_bank_parity_guard.sv
// Directed bench for the parity guard; each task checks its own scenario.
module tb_bank_parity_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid;
    logic       acc_write;
    logic [3:0] bank_sel;
    logic [7:0] acc_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       err_clear;
    logic       halt_req;
    logic [3:0] err_bank;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    bank_parity_guard dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .bank_sel(bank_sel), .acc_addr(acc_addr), .wr_data(wr_data),
        .rd_data(rd_data), .err_clear(err_clear), .halt_req(halt_req),
        .err_bank(err_bank)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual {halt,bank}=%b expected %b", req, act, exp);
        end
    endtask

    // One access cycle; outputs are sampled at the next falling edge.
    task automatic access(input logic wr, input logic [3:0] sel, input logic [7:0] a,
                          input logic [7:0] wd, input logic [7:0] rd, input logic clr);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; bank_sel = sel; acc_addr = a;
        wr_data = wd; rd_data = rd; err_clear = clr;
        @(negedge clk);
        acc_valid = 1'b0; err_clear = 1'b0;
    endtask

    task automatic idle_cycle(input logic clr, input logic [7:0] rd);
        @(negedge clk);
        acc_valid = 1'b0; err_clear = clr; rd_data = rd; bank_sel = 4'b0001;
        @(negedge clk);
        err_clear = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; bank_sel = '0;
        acc_addr = '0; wr_data = '0; rd_data = '0; err_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R8 reset", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0100, 8'd5, 8'h00, 8'h00, 1'b0);
        check("R8 unwritten zero passes", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0010, 8'd9, 8'h00, 8'h01, 1'b0);
        check("R8 unwritten 01 fails, R4 bank1", {halt_req, err_bank}, 5'b1_0010);
        idle_cycle(1'b1, 8'h00);
        check("R7 clear", {halt_req, err_bank}, 5'b0_0000);
    endtask

    task automatic t_basic;
        access(1'b1, 4'b0001, 8'h10, 8'hA5, 8'h00, 1'b0);
        access(1'b0, 4'b0001, 8'h10, 8'h00, 8'hA5, 1'b0);
        check("R1 R2 good readback", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0001, 8'h10, 8'h00, 8'hA4, 1'b0);
        check("R3 R4 single flip bank0", {halt_req, err_bank}, 5'b1_0001);
        access(1'b1, 4'b1000, 8'h22, 8'h00, 8'h00, 1'b0);
        access(1'b0, 4'b1000, 8'h22, 8'h00, 8'h40, 1'b0);
        check("R5 first error kept", {halt_req, err_bank}, 5'b1_0001);
        idle_cycle(1'b1, 8'h00);
        check("R7 clear after sticky", {halt_req, err_bank}, 5'b0_0000);
    endtask

    task automatic t_banks;
        access(1'b1, 4'b0010, 8'd7, 8'h01, 8'h00, 1'b0);
        access(1'b1, 4'b0100, 8'd7, 8'h03, 8'h00, 1'b0);
        access(1'b0, 4'b0010, 8'd7, 8'h00, 8'h01, 1'b0);
        check("R10 bank1 own bit", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0100, 8'd7, 8'h00, 8'h03, 1'b0);
        check("R10 bank2 own bit", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0100, 8'd7, 8'h00, 8'h01, 1'b0);
        check("R10 R4 bank2 fails", {halt_req, err_bank}, 5'b1_0100);
        idle_cycle(1'b1, 8'h00);
    endtask

    task automatic t_clear_collide;
        access(1'b1, 4'b1000, 8'd3, 8'hF0, 8'h00, 1'b0);
        access(1'b0, 4'b1000, 8'd3, 8'h00, 8'hF1, 1'b0);
        check("R3 bank3 fails", {halt_req, err_bank}, 5'b1_1000);
        access(1'b0, 4'b0001, 8'h10, 8'h00, 8'h25, 1'b1);
        check("R7 error wins over clear", {halt_req, err_bank}, 5'b1_0001);
        idle_cycle(1'b1, 8'h00);
        check("R7 clear alone", {halt_req, err_bank}, 5'b0_0000);
    endtask

    task automatic t_ignored;
        access(1'b1, 4'b0001, 8'd40, 8'h07, 8'hFE, 1'b0);
        check("R6 write ignores rd_data", {halt_req, err_bank}, 5'b0_0000);
        idle_cycle(1'b0, 8'h01);
        check("R6 idle ignored", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0001, 8'd40, 8'h00, 8'h07, 1'b0);
        check("R6 R1 write took effect", {halt_req, err_bank}, 5'b0_0000);
        access(1'b1, 4'b0011, 8'd20, 8'h01, 8'h00, 1'b0);
        access(1'b0, 4'b0001, 8'd20, 8'h00, 8'h00, 1'b0);
        check("R9 bad strobe write dropped", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0011, 8'd20, 8'h00, 8'h01, 1'b0);
        check("R9 bad strobe read unchecked", {halt_req, err_bank}, 5'b0_0000);
        access(1'b0, 4'b0000, 8'd20, 8'h00, 8'h01, 1'b0);
        check("R9 no strobe unchecked", {halt_req, err_bank}, 5'b0_0000);
    endtask

    task automatic t_double;
        access(1'b1, 4'b0001, 8'd30, 8'h0F, 8'h00, 1'b0);
        access(1'b0, 4'b0001, 8'd30, 8'h00, 8'h0C, 1'b0);
        check("R11 double flip missed", {halt_req, err_bank}, 5'b0_0000);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_banks();
        t_clear_collide();
        t_ignored();
        t_double();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule